// File: doc/BRIEF.md
# Time-Signal Second Classifier

This block watches the logic output of a long-wave time receiver, where high means the carrier is off (a 1) and low means the carrier is on (a 0). Every one-second segment opens with a rising edge. The block times the high pulses inside each segment with a 1 ms tick. When the segment closes, it reports the segment as one of four A/B bit pairs, as a minute marker, or as a fault.

The acceptance windows leave room for receiver distortion. High pulses come out stretched, and in the A=0,B=1 case the low gap between the two humps is shortened. A minute marker counts only when the eight A bits reported just before it read 0,1,1,1,1,1,1,0. Assembling frames from the reported seconds is left to logic downstream.

Top module: `tsig_sec_classifier`

## Requirements
- R1: After reset, every output is 0. The first rising edge of `rx_bit` after reset, or after a timeout, opens a segment and produces no strobe.
- R2: A pulse width is the number of `tick_ms` pulses that occur while `rx_bit` is high, counted from the rising edge. A segment with a single high pulse of 80 to 170 ticks reports A=0, B=0.
- R3: A single high pulse of 180 to 260 ticks reports A=1, B=0.
- R4: A single high pulse of 270 to 380 ticks reports A=1, B=1.
- R5: Two high pulses report A=0, B=1 when all three conditions hold: the first pulse lasts 80 to 170 ticks, the second pulse begins 160 to 240 ticks after the opening edge, and the second pulse lasts 60 to 160 ticks.
- R6: A rising edge that comes 900 or more ticks after the opening edge closes the segment. The block then raises `sec_stb` for one clock and updates `bit_a`, `bit_b`, `marker` and `err`, which keep their values until the next strobe. A rising edge that comes earlier belongs to the current segment.
- R7: Any other shape makes the segment report `err`=1 with A, B and `marker` all 0. This covers widths outside every window, a second pulse that starts outside its window or has the wrong width, and a third pulse.
- R8: A single high pulse of 440 to 600 ticks reports `marker`=1 (with A=0, B=0, `err`=0) only when the A bits of the eight preceding good ordinary segments, oldest first, are 0,1,1,1,1,1,1,0.
- R9: A marker-shaped segment whose history does not match that pattern reports `err`=1 and `marker`=0.
- R10: Each good ordinary segment shifts its A bit into the history. A marker, a fault or a timeout clears the history, so a new marker then needs eight fresh good segments.
- R11: If a segment reaches 1101 ticks without a closing edge, the block strobes with `err`=1 at that tick. It then waits for a new rising edge, which opens a segment without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| rx_bit | input | 1 | Synchronized receiver output, high = carrier off |
| sec_stb | output | 1 | One-clock pulse when a segment result is ready |
| bit_a | output | 1 | A bit of the last segment |
| bit_b | output | 1 | B bit of the last segment |
| marker | output | 1 | Last segment was a confirmed minute marker |
| err | output | 1 | Last segment was malformed or timed out |

## Verification
The bench builds the block with its default windows: 80/170, 180/260, 270/380 and 440/600 ticks for single pulses, 160/240 for the second-pulse start, 60/160 for the second-pulse width, and 900/1100 for the segment limits. The bench raises the tick every fourth clock. This keeps a full segment near 4000 clocks, so about two dozen segments and a timeout fit in one run. Edges are placed between ticks, which makes every measured width exact. The window edges (79, 80, 170, 175) can therefore be hit to the tick, and a whole eight-segment marker preamble followed by a marker can be run.

// File: rtl/tsig_sec_classifier.sv
module tsig_sec_classifier #(
  parameter int W00_MIN  = 80,
  parameter int W00_MAX  = 170,
  parameter int W10_MIN  = 180,
  parameter int W10_MAX  = 260,
  parameter int W11_MIN  = 270,
  parameter int W11_MAX  = 380,
  parameter int WMK_MIN  = 440,
  parameter int WMK_MAX  = 600,
  parameter int BST_MIN  = 160,
  parameter int BST_MAX  = 240,
  parameter int BW_MIN   = 60,
  parameter int BW_MAX   = 160,
  parameter int SEG_MIN  = 900,
  parameter int SEG_MAX  = 1100,
  parameter int HIST_LEN = 8,
  parameter logic [HIST_LEN-1:0] MARK_PAT = 8'b0111_1110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic rx_bit,
  output logic sec_stb,
  output logic bit_a,
  output logic bit_b,
  output logic marker,
  output logic err
);

  localparam int CW = $clog2(SEG_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_HI1, S_LO1, S_HI2, S_LO2} ph_t;

  ph_t                 ph;
  logic [CW-1:0]       cnt, w1, s2, w2;
  logic                extra, rx_q;
  logic [HIST_LEN-1:0] hist;
  logic                c_a, c_b, c_mk, c_err;

  function automatic logic in_win(logic [CW-1:0] v, int lo, int hi);
    return (int'(v) >= lo) && (int'(v) <= hi);
  endfunction

  wire rise    = rx_bit & ~rx_q;
  wire fall    = ~rx_bit & rx_q;
  wire end_seg = rise && (ph == S_LO1 || ph == S_LO2) && (int'(cnt) >= SEG_MIN);
  wire tmo     = tick_ms && (ph != S_IDLE) && (int'(cnt) == SEG_MAX);

  always_comb begin
    c_a = 1'b0; c_b = 1'b0; c_mk = 1'b0; c_err = 1'b0;
    if (extra) begin
      c_err = 1'b1;
    end else if (ph == S_LO1) begin
      if (in_win(w1, W00_MIN, W00_MAX)) begin
        c_a = 1'b0;
      end else if (in_win(w1, W10_MIN, W10_MAX)) begin
        c_a = 1'b1;
      end else if (in_win(w1, W11_MIN, W11_MAX)) begin
        c_a = 1'b1; c_b = 1'b1;
      end else if (in_win(w1, WMK_MIN, WMK_MAX) && hist == MARK_PAT) begin
        c_mk = 1'b1;
      end else begin
        c_err = 1'b1;
      end
    end else if (ph == S_LO2) begin
      if (in_win(w1, W00_MIN, W00_MAX) && in_win(s2, BST_MIN, BST_MAX) &&
          in_win(w2, BW_MIN, BW_MAX))
        c_b = 1'b1;
      else
        c_err = 1'b1;
    end else begin
      c_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= S_IDLE; cnt <= '0; w1 <= '0; s2 <= '0; w2 <= '0;
      extra <= 1'b0; rx_q <= 1'b1; hist <= '1;
      sec_stb <= 1'b0; bit_a <= 1'b0; bit_b <= 1'b0; marker <= 1'b0; err <= 1'b0;
    end else begin
      rx_q    <= rx_bit;
      sec_stb <= 1'b0;
      if (end_seg) begin
        sec_stb <= 1'b1;
        bit_a <= c_a; bit_b <= c_b; marker <= c_mk; err <= c_err;
        hist  <= (c_err || c_mk) ? '1 : {hist[HIST_LEN-2:0], c_a};
        ph <= S_HI1; cnt <= '0; extra <= 1'b0;
        w1 <= '0; s2 <= '0; w2 <= '0;
      end else if (tmo) begin
        sec_stb <= 1'b1;
        bit_a <= 1'b0; bit_b <= 1'b0; marker <= 1'b0; err <= 1'b1;
        hist <= '1; ph <= S_IDLE; cnt <= '0;
      end else begin
        if (tick_ms && ph != S_IDLE) cnt <= cnt + 1'b1;
        case (ph)
          S_IDLE: if (rise) begin ph <= S_HI1; cnt <= '0; extra <= 1'b0; end
          S_HI1:  if (fall) begin w1 <= cnt; ph <= S_LO1; end
          S_LO1:  if (rise) begin s2 <= cnt; ph <= S_HI2; end
          S_HI2:  if (fall) begin w2 <= cnt - s2; ph <= S_LO2; end
          S_LO2:  if (rise) begin s2 <= cnt; extra <= 1'b1; ph <= S_HI2; end
          default: ph <= S_IDLE;
        endcase
      end
    end
  end

  // R6
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb |=> !sec_stb);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_stb |-> $stable({bit_a, bit_b, marker, err}));

  // R7
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bit_a && !bit_b && !marker);

  // R8
  mark_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    marker |-> !bit_a && !bit_b && !err);

  // R8
  mark_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && marker) |-> ($past(hist) == MARK_PAT));

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= SEG_MAX);

endmodule

// File: tb/tsig_sec_classifier_bench.sv
module tsig_sec_classifier_bench;
  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0;
  logic [1:0] div;
  logic tick_ms, sec_stb, bit_a, bit_b, marker, err;
  int total = 0, bad = 0, stb_n = 0, exp_n = 0, cyc = 0;
  logic [3:0] cap;
  bit done = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) div <= '0;
    else        div <= div + 2'd1;
  end
  assign tick_ms = (div == 2'd3);

  tsig_sec_classifier u_tsig_sec_classifier (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rx_bit(rx_bit),
    .sec_stb(sec_stb), .bit_a(bit_a), .bit_b(bit_b), .marker(marker), .err(err));

  always @(negedge clk) begin
    if (sec_stb) begin
      stb_n++;
      cap = {bit_a, bit_b, marker, err};
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick_ms);
      @(negedge clk);
    end
  endtask

  // rx is high on entry: the segment was opened by the previous close
  task automatic run_sec(int h1, int l1, int h2, int tot);
    wait_ticks(h1);
    rx_bit = 1'b0;
    if (h2 > 0) begin
      wait_ticks(l1);
      rx_bit = 1'b1;
      wait_ticks(h2);
      rx_bit = 1'b0;
      wait_ticks(tot - h1 - l1 - h2);
    end else begin
      wait_ticks(tot - h1);
    end
  endtask

  // closing rising edge; expect {a,b,marker,err}
  task automatic close(logic [3:0] expv, string req);
    rx_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    exp_n++;
    check(stb_n == exp_n, {req, " strobe count"}, stb_n, exp_n);
    check(cap == expv, req, cap, expv);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    check({sec_stb, bit_a, bit_b, marker, err} == 5'b0, "R1 reset outputs",
          {sec_stb, bit_a, bit_b, marker, err}, 0);
    rst_n = 1'b1;
    wait_ticks(20);
    rx_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    check(stb_n == 0, "R1 first edge no strobe", stb_n, 0);
  endtask

  task automatic t_basic;
    run_sec(125, 0, 0, 1000);  close(4'b0000, "R2 A0B0 125");
    run_sec(224, 0, 0, 1000);  close(4'b1000, "R3 A1B0 224");
    run_sec(316, 0, 0, 1000);  close(4'b1100, "R4 A1B1 316");
    run_sec(124, 76, 106, 1000); close(4'b0100, "R5 A0B1 short gap");
  endtask

  task automatic t_bounds;
    run_sec(80, 0, 0, 1000);   close(4'b0000, "R2 lower edge 80");
    run_sec(170, 0, 0, 1000);  close(4'b0000, "R2 upper edge 170");
    run_sec(175, 0, 0, 1000);  close(4'b0001, "R7 width 175 between windows");
    run_sec(79, 0, 0, 1000);   close(4'b0001, "R7 width 79 too short");
    run_sec(120, 130, 100, 1000); close(4'b0001, "R7 second pulse late start 250");
    run_sec(120, 80, 200, 1000);  close(4'b0001, "R7 second pulse too wide");
  endtask

  task automatic t_three_pulses;
    wait_ticks(120); rx_bit = 1'b0;
    wait_ticks(80);  rx_bit = 1'b1;
    wait_ticks(100); rx_bit = 1'b0;
    wait_ticks(200); rx_bit = 1'b1;
    wait_ticks(50);  rx_bit = 1'b0;
    wait_ticks(450);
    close(4'b0001, "R7 third pulse");
  endtask

  task automatic t_early_rise;
    run_sec(500, 300, 60, 1000);
    close(4'b0001, "R6 rise at 800 stays in segment");
  endtask

  task automatic t_marker;
    run_sec(520, 0, 0, 1000); close(4'b0001, "R9 marker without history");
    run_sec(125, 0, 0, 1000); close(4'b0000, "R10 pre 0");
    run_sec(224, 0, 0, 1000); close(4'b1000, "R10 pre 1");
    run_sec(316, 0, 0, 1000); close(4'b1100, "R10 pre 1");
    run_sec(224, 0, 0, 1000); close(4'b1000, "R10 pre 1");
    run_sec(316, 0, 0, 1000); close(4'b1100, "R10 pre 1");
    run_sec(224, 0, 0, 1000); close(4'b1000, "R10 pre 1");
    run_sec(316, 0, 0, 1000); close(4'b1100, "R10 pre 1");
    run_sec(124, 80, 100, 1000); close(4'b0100, "R10 pre 0 via A0B1");
    run_sec(520, 0, 0, 1000); close(4'b0010, "R8 marker confirmed");
    run_sec(520, 0, 0, 1000); close(4'b0001, "R10 history cleared by marker");
  endtask

  task automatic t_timeout;
    wait_ticks(1101);
    @(negedge clk);
    exp_n++;
    check(stb_n == exp_n, "R11 timeout strobe", stb_n, exp_n);
    check(cap == 4'b0001, "R11 timeout err", cap, 4'b0001);
    rx_bit = 1'b0;
    wait_ticks(50);
    rx_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    check(stb_n == exp_n, "R11 idle edge no strobe", stb_n, exp_n);
    run_sec(224, 0, 0, 1000); close(4'b1000, "R11 resume after timeout");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bounds();
    t_three_pulses();
    t_early_rise();
    t_marker();
    t_timeout();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule